// File: doc/BRIEF.md
# Multi-stage hashed heavy-hitter table

This block keeps an approximate record of the heaviest flows in a packet stream. It is a chain of hashed stages. Each stage owns a private table of entries, and each entry holds a flow identifier, a packet count and an occupied flag. One flow identifier can arrive per clock on a valid/ready handshake.

The first stage always installs the arriving flow. If the flow is already in the indexed slot, its count goes up by one. If not, the slot's previous occupant is pushed down the chain as a carried (key, count) pair. Each later stage hashes the carried key into its own table. On a key match it merges the two counts. Otherwise it keeps whichever of the two counts is larger and passes the other one on. A pair that falls off the end of the chain is lost, so no packet ever loops back.

A scan port reads any entry of any stage, one per request, for an external top-k report. A clear input empties every table; while the clear runs, arrivals are held off.

Top module: `hh_table`

## Requirements
- R1: After reset every entry of every stage is empty: a scan returns valid 0, key 0 and count 0. in_ready is 1.
- R2: Stage s indexes its table with the low log2(DEPTH) bits of a CRC-16 of the key. The CRC uses polynomial 0x1021 with no reflection and shifts in the key's FW bits starting from the most significant. Its initial value is 0xFFFF XOR ((s * 0x2F4B) mod 2^16).
- R3: When an accepted flow equals the key in its first-stage slot, that slot's count rises by 1 and no other entry changes.
- R4: When an accepted flow does not match its first-stage slot, the slot takes the flow with count 1. The previous occupant, if there was one, becomes the carried pair for stage 1.
- R5: In a stage after the first, a carried key equal to the indexed entry's key adds the carried count to that entry (saturating at the count maximum), and the carried pair ends there.
- R6: In a stage after the first, a carried count strictly greater than the indexed entry's count swaps with the entry, and the displaced pair is carried on. An empty entry counts as 0. An equal or smaller carried count passes on unchanged and the entry is untouched.
- R7: One flow may sit in several stages at once and these copies are never merged. A pair still carried after the last stage is discarded.
- R8: Accepting the same flow on consecutive cycles counts every one of them.
- R9: A clear pulse while no clear is running empties every entry. in_ready is 0 in the cycle clear is high and for the DEPTH cycles after it, and pairs in flight at that moment are dropped.
- R10: The scan address (rd_stage, rd_idx) is sampled at a clock edge and its entry appears on rd_valid, rd_key and rd_count after that edge. An empty entry reads as key 0 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Pulse to start emptying all tables |
| in_valid | input | 1 | Flow identifier present |
| in_ready | output | 1 | Block can take a flow identifier this cycle |
| in_flow | input | FW | Flow identifier |
| rd_stage | input | log2(NSTAGE) | Stage to scan |
| rd_idx | input | log2(DEPTH) | Entry to scan |
| rd_valid | output | 1 | Scanned entry is occupied |
| rd_key | output | FW | Scanned entry key (0 when empty) |
| rd_count | output | CW | Scanned entry count (0 when empty) |

## Verification
The checker watches several properties on every cycle. An accepted flow is always written into the first stage. No table is written while a clear runs. Every carried pair has a non-zero count. An empty scan result reads as zeros. Whether counts end up in the right slots depends on the hash and on the order of arrivals, so only the bench can show it. The bench scans the whole table and compares it against its own model after a stream that mixes repeats, collisions and idle gaps. It also runs directed scenarios for eviction, merging, duplicates, back-to-back repeats and a clear that lands while pairs are still in flight.

// File: rtl/hh_pkg.sv
// Shared helpers for the heavy-hitter table.
// Assumes keys are at most 64 bits wide.
package hh_pkg;

    // Seeded CRC-16 (poly 0x1021, MSB first) over the low nbits of data.
    function automatic logic [15:0] crc16_hash(input logic [63:0] data,
                                               input int unsigned nbits,
                                               input int unsigned stage);
        logic [15:0] crc;
        logic        fb;
        crc = 16'hFFFF ^ (16'(stage) * 16'h2F4B);
        for (int i = 63; i >= 0; i--) begin
            if (i < int'(nbits)) begin
                fb  = crc[15] ^ data[i];
                crc = {crc[14:0], 1'b0};
                if (fb) crc = crc ^ 16'h1021;
            end
        end
        return crc;
    endfunction

endpackage

// File: rtl/hh_clear_ctl.sv
// Clear sequencer: on a clear pulse while idle, walks one index per cycle
// across all tables for DEPTH cycles. kill is high in the pulse cycle and
// while walking, and it stalls input and flushes carried pairs.
module hh_clear_ctl #(
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic          busy,
    output logic [IW-1:0] ptr,
    output logic          kill
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    // Start, advance and finish the clear walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ptr  <= '0;
        end else if (!busy && clear) begin
            busy <= 1'b1;
            ptr  <= '0;
        end else if (busy) begin
            ptr <= ptr + 1'b1;
            if (ptr == LAST) busy <= 1'b0;
        end
    end

    // Stall and flush while a clear is requested or running.
    always_comb kill = clear || busy;

endmodule

// File: rtl/hh_stage.sv
// One hashed stage. It reads, compares and writes its own table in a single
// cycle and registers the carried pair for the next stage. Stage 0 always
// installs the incoming key. Later stages merge on a key match and otherwise
// keep the larger count. Reads are from flops, so an update written at one
// edge is seen by the next cycle's read without any bypass.
module hh_stage #(
    parameter int STAGE = 0,
    parameter int FW    = 32,
    parameter int CW    = 16,
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [FW-1:0] in_key,
    input  logic [CW-1:0] in_cnt,
    input  logic          kill,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          out_vld,
    output logic [FW-1:0] out_key,
    output logic [CW-1:0] out_cnt,
    output logic          rd_vld,
    output logic [FW-1:0] rd_key,
    output logic [CW-1:0] rd_cnt,
    output logic          wr_en,
    output logic [FW-1:0] wr_key,
    output logic [CW-1:0] wr_cnt
);
    import hh_pkg::*;

    localparam bit IS_FIRST = (STAGE == 0);

    logic [DEPTH-1:0] vld_q;
    logic [FW-1:0]    key_q [DEPTH];
    logic [CW-1:0]    cnt_q [DEPTH];

    logic [IW-1:0] idx;
    logic          e_vld;
    logic [FW-1:0] e_key;
    logic [CW-1:0] e_cnt;
    logic          hit;
    logic [CW:0]   sum;
    logic [CW-1:0] sat;
    logic          nx_vld;
    logic [FW-1:0] nx_key;
    logic [CW-1:0] nx_cnt;

    // Hash the incoming key into this stage's index.
    always_comb idx = IW'(crc16_hash(64'(in_key), FW, STAGE));

    // Look up the indexed entry; an empty entry counts as zero.
    always_comb begin
        e_vld = vld_q[idx];
        e_key = key_q[idx];
        e_cnt = e_vld ? cnt_q[idx] : '0;
        hit   = e_vld && (e_key == in_key);
        sum   = {1'b0, e_cnt} + {1'b0, in_cnt};
        sat   = sum[CW] ? '1 : sum[CW-1:0];
    end

    // Decide the table write and the pair carried to the next stage.
    always_comb begin
        wr_en  = 1'b0;
        wr_key = in_key;
        wr_cnt = in_cnt;
        nx_vld = 1'b0;
        nx_key = e_key;
        nx_cnt = e_cnt;
        if (in_vld && !kill) begin
            if (hit) begin
                wr_en  = 1'b1;
                wr_cnt = sat;
            end else if (IS_FIRST || (in_cnt > e_cnt)) begin
                wr_en  = 1'b1;
                nx_vld = e_vld;
            end else begin
                nx_vld = 1'b1;
                nx_key = in_key;
                nx_cnt = in_cnt;
            end
        end
    end

    // Occupied flags: the clear walk or an insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr_en) begin
            vld_q[clr_idx] <= 1'b0;
        end else if (wr_en) begin
            vld_q[idx] <= 1'b1;
        end
    end

    // Entry payload update.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            key_q[idx] <= wr_key;
            cnt_q[idx] <= wr_cnt;
        end
    end

    // Carried-pair valid register, flushed by kill through nx_vld.
    always_ff @(posedge clk) begin
        if (!rst_n) out_vld <= 1'b0;
        else        out_vld <= nx_vld;
    end

    // Carried-pair payload register.
    always_ff @(posedge clk) begin
        out_key <= nx_key;
        out_cnt <= nx_cnt;
    end

    // Scan read port; empty entries read as zero.
    always_comb begin
        rd_vld = vld_q[rd_idx];
        rd_key = rd_vld ? key_q[rd_idx] : '0;
        rd_cnt = rd_vld ? cnt_q[rd_idx] : '0;
    end

endmodule

// File: rtl/hh_table.sv
// Heavy-hitter table: NSTAGE hashed stages in a chain, a clear sequencer and
// a registered scan port. Assumes NSTAGE >= 2, DEPTH a power of two, FW <= 64.
module hh_table #(
    parameter int NSTAGE = 4,
    parameter int DEPTH  = 16,
    parameter int FW     = 32,
    parameter int CW     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [FW-1:0]             in_flow,
    input  logic [$clog2(NSTAGE)-1:0] rd_stage,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    output logic                      rd_valid,
    output logic [FW-1:0]             rd_key,
    output logic [CW-1:0]             rd_count
);
    localparam int IW = $clog2(DEPTH);

    logic          clr_busy;
    logic [IW-1:0] clr_ptr;
    logic          kill;

    logic [NSTAGE:0]          c_vld;
    logic [NSTAGE:0][FW-1:0]  c_key;
    logic [NSTAGE:0][CW-1:0]  c_cnt;

    logic [NSTAGE-1:0]         s_wr_en;
    logic [NSTAGE-1:0][FW-1:0] s_wr_key;
    logic [NSTAGE-1:0][CW-1:0] s_wr_cnt;
    logic [NSTAGE-1:0]         s_rd_vld;
    logic [NSTAGE-1:0][FW-1:0] s_rd_key;
    logic [NSTAGE-1:0][CW-1:0] s_rd_cnt;

    hh_clear_ctl #(.DEPTH(DEPTH), .IW(IW)) u_clr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .busy  (clr_busy),
        .ptr   (clr_ptr),
        .kill  (kill)
    );

    // Input handshake and the first-stage feed (each arrival counts 1).
    always_comb begin
        in_ready = !kill;
        c_vld[0] = in_valid && in_ready;
        c_key[0] = in_flow;
        c_cnt[0] = CW'(1);
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        hh_stage #(
            .STAGE (s),
            .FW    (FW),
            .CW    (CW),
            .DEPTH (DEPTH),
            .IW    (IW)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_vld  (c_vld[s]),
            .in_key  (c_key[s]),
            .in_cnt  (c_cnt[s]),
            .kill    (kill),
            .clr_en  (clr_busy),
            .clr_idx (clr_ptr),
            .rd_idx  (rd_idx),
            .out_vld (c_vld[s+1]),
            .out_key (c_key[s+1]),
            .out_cnt (c_cnt[s+1]),
            .rd_vld  (s_rd_vld[s]),
            .rd_key  (s_rd_key[s]),
            .rd_cnt  (s_rd_cnt[s]),
            .wr_en   (s_wr_en[s]),
            .wr_key  (s_wr_key[s]),
            .wr_cnt  (s_wr_cnt[s])
        );
    end

    // Registered scan result for the addressed stage and entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_key   <= '0;
            rd_count <= '0;
        end else if (int'(rd_stage) < NSTAGE) begin
            rd_valid <= s_rd_vld[rd_stage];
            rd_key   <= s_rd_key[rd_stage];
            rd_count <= s_rd_cnt[rd_stage];
        end else begin
            rd_valid <= 1'b0;
            rd_key   <= '0;
            rd_count <= '0;
        end
    end

endmodule

// File: rtl/hh_table_chk.sv
// Property checker for hh_table, attached through bind. It watches the
// handshake, the per-stage write strobes, the carried pairs and the scan port.
module hh_table_chk #(
    parameter int NSTAGE = 4,
    parameter int FW     = 32,
    parameter int CW     = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clear,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [FW-1:0]             in_flow,
    input logic                      clr_busy,
    input logic [NSTAGE-1:0]         wr_en,
    input logic [NSTAGE-1:0][FW-1:0] wr_key,
    input logic [NSTAGE-1:0][CW-1:0] wr_cnt,
    input logic [NSTAGE:0]           c_vld,
    input logic [NSTAGE:0][CW-1:0]   c_cnt,
    input logic                      rd_valid,
    input logic [FW-1:0]             rd_key,
    input logic [CW-1:0]             rd_count
);
    // R4 (and R3): an accepted flow is always written into the first stage.
    p_first_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (wr_en[0] && wr_key[0] == in_flow));

    // R3: the first stage never writes a zero count.
    p_first_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |-> (wr_cnt[0] != '0));

    // R9: a clear from idle makes the walk run and holds off input.
    p_clear_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !clr_busy) |=> (clr_busy && !in_ready));

    // R9: no table is written while a clear is requested or running.
    p_no_write_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || clr_busy) |-> (wr_en == '0));

    // R10: an empty scan result reads as zeros.
    p_scan_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_key == '0 && rd_count == '0));

    // R6: every carried pair, including the one leaving the last stage, counts at least 1.
    for (genvar s = 0; s <= NSTAGE; s++) begin : g_carry
        p_carry_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
            c_vld[s] |-> (c_cnt[s] != '0));
    end

endmodule

bind hh_table hh_table_chk #(.NSTAGE(NSTAGE), .FW(FW), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_flow  (in_flow),
    .clr_busy (clr_busy),
    .wr_en    (s_wr_en),
    .wr_key   (s_wr_key),
    .wr_cnt   (s_wr_cnt),
    .c_vld    (c_vld),
    .c_cnt    (c_cnt),
    .rd_valid (rd_valid),
    .rd_key   (rd_key),
    .rd_count (rd_count)
);

// File: tb/tb_hh_table.sv
// Self-checking bench for hh_table. A vector table of flows with optional idle
// gaps is walked by one loop, and a behavioural model built from the
// requirements supplies every expected entry. Directed tests follow.
module tb_hh_table;
    localparam int NSTAGE = 4;
    localparam int DEPTH  = 16;
    localparam int FW     = 32;
    localparam int CW     = 16;
    localparam int SW     = $clog2(NSTAGE);
    localparam int IW     = $clog2(DEPTH);
    localparam int NVEC   = 24;

    // Bit 32 = one idle cycle before this flow; bits 31:0 = flow identifier.
    localparam logic [32:0] VEC [NVEC] = '{
        33'h0_0000_0011, 33'h0_0000_0022, 33'h0_0000_0011, 33'h0_0000_0033,
        33'h1_0000_0011, 33'h0_0000_0044, 33'h0_0000_0055, 33'h0_0000_0022,
        33'h0_0000_0066, 33'h1_0000_0077, 33'h0_0000_0011, 33'h0_0000_0088,
        33'h0_0000_0099, 33'h0_0000_00AA, 33'h1_0000_0022, 33'h0_0000_00BB,
        33'h0_0000_00CC, 33'h0_0000_0011, 33'h0_0000_00DD, 33'h0_0000_00EE,
        33'h1_0000_0033, 33'h0_0000_00FF, 33'h0_0000_0101, 33'h0_0000_0011
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FW-1:0] in_flow = '0;
    logic [SW-1:0] rd_stage = '0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [FW-1:0] rd_key;
    logic [CW-1:0] rd_count;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    logic          m_vld [NSTAGE][DEPTH];
    logic [FW-1:0] m_key [NSTAGE][DEPTH];
    logic [CW-1:0] m_cnt [NSTAGE][DEPTH];

    hh_table #(.NSTAGE(NSTAGE), .DEPTH(DEPTH), .FW(FW), .CW(CW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_flow  (in_flow),
        .rd_stage (rd_stage),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_key   (rd_key),
        .rd_count (rd_count)
    );

    always #4 clk = ~clk;

    // Index of key k in stage s, following the hashing requirement R2.
    function automatic int tb_index(input logic [FW-1:0] k, input int s);
        logic [15:0] r;
        logic        b;
        r = 16'hFFFF ^ 16'((s * 32'h2F4B) & 32'hFFFF);
        for (int i = FW - 1; i >= 0; i--) begin
            b = r[15] ^ k[i];
            r = {r[14:0], 1'b0};
            if (b) r = r ^ 16'h1021;
        end
        return int'(r) % DEPTH;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < NSTAGE; s++)
            for (int i = 0; i < DEPTH; i++) begin
                m_vld[s][i] = 1'b0;
                m_key[s][i] = '0;
                m_cnt[s][i] = '0;
            end
    endtask

    // Push one flow through the model chain (R3 to R7).
    task automatic model_push(input logic [FW-1:0] f);
        logic [FW-1:0] ck;
        logic [CW-1:0] cc;
        logic          cv;
        logic [FW-1:0] tk;
        logic [CW-1:0] tc;
        logic          tv;
        int            ix;
        int            sum;
        ix = tb_index(f, 0);
        if (m_vld[0][ix] && m_key[0][ix] == f) begin
            m_cnt[0][ix] = m_cnt[0][ix] + 1'b1;
            cv = 1'b0;
        end else begin
            cv = m_vld[0][ix]; ck = m_key[0][ix]; cc = m_cnt[0][ix];
            m_vld[0][ix] = 1'b1; m_key[0][ix] = f; m_cnt[0][ix] = 1;
        end
        for (int s = 1; s < NSTAGE; s++) begin
            if (cv) begin
                ix = tb_index(ck, s);
                if (m_vld[s][ix] && m_key[s][ix] == ck) begin
                    sum = int'(m_cnt[s][ix]) + int'(cc);
                    m_cnt[s][ix] = (sum > 65535) ? 16'hFFFF : 16'(sum);
                    cv = 1'b0;
                end else if (int'(cc) > (m_vld[s][ix] ? int'(m_cnt[s][ix]) : 0)) begin
                    tv = m_vld[s][ix]; tk = m_key[s][ix]; tc = m_cnt[s][ix];
                    m_vld[s][ix] = 1'b1; m_key[s][ix] = ck; m_cnt[s][ix] = cc;
                    cv = tv; ck = tk; cc = tc;
                end
            end
        end
    endtask

    // Present one flow for one cycle; starts and ends at a falling edge.
    task automatic send(input logic [FW-1:0] f);
        in_valid = 1'b1;
        in_flow  = f;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model_push(f);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Scan one entry: address set at a falling edge, result one edge later (R10).
    task automatic scan_one(input int s, input int i,
                            output logic v, output logic [FW-1:0] k,
                            output logic [CW-1:0] c);
        rd_stage = SW'(s);
        rd_idx   = IW'(i);
        @(posedge clk);
        @(negedge clk);
        v = rd_valid; k = rd_key; c = rd_count;
    endtask

    task automatic scan_compare(input string tag);
        logic          v;
        logic [FW-1:0] k;
        logic [CW-1:0] c;
        for (int s = 0; s < NSTAGE; s++)
            for (int i = 0; i < DEPTH; i++) begin
                scan_one(s, i, v, k, c);
                check(tag, $sformatf("stage %0d entry %0d {vld,key,cnt}", s, i),
                      64'({v, k, c}),
                      64'({m_vld[s][i],
                           m_vld[s][i] ? m_key[s][i] : 32'h0,
                           m_vld[s][i] ? m_cnt[s][i] : 16'h0}));
            end
    endtask

    task automatic spot(input string tag, input int s, input int i,
                        input logic [FW-1:0] ek, input logic [CW-1:0] ec);
        logic          v;
        logic [FW-1:0] k;
        logic [CW-1:0] c;
        scan_one(s, i, v, k, c);
        check(tag, $sformatf("stage %0d entry %0d {vld,key,cnt}", s, i),
              64'({v, k, c}), 64'({1'b1, ek, ec}));
    endtask

    task automatic do_clear(input string tag);
        clear    = 1'b1;
        in_valid = 1'b1;
        in_flow  = 32'hDEAD_0001;
        #1;
        check(tag, "in_ready in clear cycle", 64'(in_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            #1;
            check(tag, $sformatf("in_ready during clear cycle %0d", i), 64'(in_ready), 64'd0);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        #1;
        check(tag, "in_ready after clear", 64'(in_ready), 64'd1);
        model_clear();
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] fa;
        logic [FW-1:0] fb;
        model_clear();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check("R1", "in_ready after reset", 64'(in_ready), 64'd1);
        scan_compare("R1");

        // R2, R6, R7: vector walk, then the full table against the model.
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][32]) idle(1);
            send(VEC[v][31:0]);
        end
        idle(NSTAGE + 1);
        scan_compare("R2_R6_R7");

        // R9: clear issued right after traffic, with pairs still in flight.
        send(32'h0000_0011);
        send(32'h0000_0500);
        do_clear("R9");
        idle(NSTAGE + 1);
        scan_compare("R9");

        // R8 and R3: five back-to-back copies of one flow.
        fa = 32'h1234_5678;
        for (int n = 0; n < 5; n++) begin
            in_valid = 1'b1;
            in_flow  = fa;
            @(posedge clk);
            @(negedge clk);
            model_push(fa);
        end
        in_valid = 1'b0;
        idle(NSTAGE + 1);
        spot("R8", 0, tb_index(fa, 0), fa, 16'd5);
        scan_compare("R3");

        // R4, R6, R7, R5: first-stage collision between fa and fb.
        do_clear("R9");
        fb = fa;
        for (int c = 1; c < 5000; c++)
            if (fb == fa && tb_index(fa + FW'(c), 0) == tb_index(fa, 0))
                fb = fa + FW'(c);
        send(fa); send(fa); send(fa);
        send(fb);
        idle(NSTAGE + 1);
        spot("R4", 0, tb_index(fa, 0), fb, 16'd1);
        spot("R6", 1, tb_index(fa, 1), fa, 16'd3);
        send(fa);
        idle(NSTAGE + 1);
        spot("R7", 0, tb_index(fa, 0), fa, 16'd1);
        spot("R7", 1, tb_index(fa, 1), fa, 16'd3);
        send(fb);
        idle(NSTAGE + 1);
        spot("R5", 1, tb_index(fa, 1), fa, 16'd4);
        spot("R4", 0, tb_index(fa, 0), fb, 16'd1);
        scan_compare("R7");

        // R10: scan of an entry that is empty after a clear.
        do_clear("R9");
        idle(2);
        scan_compare("R10");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule